// File: doc/BRIEF.md
# Boot Hold Reset Controller

This block sequences the resets of a processor subsystem that boots from RAM rather than from a ROM. When power-on reset is removed, the debug and bus-access side comes out of reset first. The core stays in system reset during this phase. In that window the block grants an external master access to RAM over the system bus. That master can be a debug access port or another processor, and it copies the boot image in. The core is released only after the loader reports that the image is complete.

The core can also ask for a system reset by software. This resets the core alone and leaves the debug side running. A strap input selects what happens after such a reset. With the strap set, RAM is reopened for a fresh load. With the strap clear, the core runs again without a reload.

Two test inputs support scan. One overrides every reset the block generates. The other forces a bank of clock-gate enables on.

Top module: `boot_reset_ctrl`

## Requirements
- R1: While `por_rst` is 1 (and `test_rst_bypass` is 0), `dbg_rst` and `sys_rst` are both 1 and `ram_grant` is 0.
- R2: `dbg_rst` is asserted at once when `por_rst` rises. After `por_rst` falls, `dbg_rst` stays 1 through the first rising clock edge and drops after the second.
- R3: On the rising edge after the one that releases `dbg_rst`, `ram_grant` goes to 1 while `sys_rst` stays 1. Both hold for as long as `load_done` stays 0.
- R4: When `load_done` is 1 at a rising edge while access is granted, `ram_grant` drops after that edge. `sys_rst` drops after the second edge that follows.
- R5: `sys_rst` is 1 in every cycle in which `ram_grant` is 1, so the core never runs while the loader owns RAM.
- R6: When `sw_reset_req` is 1 at a rising edge while the core runs, `sys_rst` rises right after that edge. `dbg_rst` stays 0.
- R7: A software reset holds the core for SW_HOLD cycles (default 4). With `boot_from_ram` at 0, `sys_rst` then drops after edge SW_HOLD+2, counted from the request edge. `ram_grant` stays 0 throughout.
- R8: With `boot_from_ram` at 1, a software reset raises `ram_grant` after edge SW_HOLD, counted from the request edge. The core is then held until a new `load_done`.
- R9: `load_done` has no effect unless access is granted. `sw_reset_req` has no effect unless the core is running.
- R10: While `test_rst_bypass` is 1, `dbg_rst` and `sys_rst` are both 0, even during power-on reset.
- R11: `gate_en_out[i]` equals `gate_en_in[i]` when `test_cg_bypass` is 0. All bits of `gate_en_out` are 1 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the reset domain |
| por_rst | input | 1 | Power-on reset, active high, asynchronous |
| load_done | input | 1 | Loader reports the boot image is in RAM |
| sw_reset_req | input | 1 | System reset request from the core |
| boot_from_ram | input | 1 | Strap: reload RAM after a software reset |
| test_rst_bypass | input | 1 | Scan: override all generated resets |
| test_cg_bypass | input | 1 | Scan: force all clock-gate enables on |
| gate_en_in | input | N_GATES | Functional clock-gate enables |
| dbg_rst | output | 1 | Reset of debug and bus-access logic, active high |
| sys_rst | output | 1 | Reset of the core, active high |
| ram_grant | output | 1 | External master may access RAM |
| gate_en_out | output | N_GATES | Clock-gate enables after the scan override |

## Verification
Some properties are checked by assertions on every cycle. The core is always held in reset while RAM access is granted. The debug reset never returns once released, except on a new power-on reset. The grant holds until `load_done` arrives and drops right after it. A running core that requests reset gets its hold register raised on the next edge. The software hold counter stays inside its range. Other behaviour depends on cycle counts and on the strap and test inputs, so only the bench's directed scenarios can show it. This covers the exact edge on which each reset releases, the two endings of a software reset, ignored inputs in the wrong state, and the scan overrides.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,  // after power-on, core and loader both idle
    ST_LOAD  = 2'd1,  // loader owns RAM, core held
    ST_RUN   = 2'd2,  // core released
    ST_SWRST = 2'd3   // software requested core reset
  } brc_state_e;
endpackage

// File: rtl/brc_rst_sync.sv
module brc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '1;
    else      chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain[STAGES-1];

  // R2: once released, the output stays low until the async input returns
  a_r2_release_sticky: assert property (@(posedge clk) disable iff (arst)
    !rst_out |=> !rst_out);
endmodule

// File: rtl/brc_seq_fsm.sv
module brc_seq_fsm
  import brc_pkg::*;
#(
  parameter int SW_HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load_done,
  input  logic sw_req,
  input  logic strap,
  output logic hold_o,
  output logic grant_o
);
  localparam int CNT_W = $clog2(SW_HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SW_HOLD - 1);

  brc_state_e state, nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_HOLD:  nxt = ST_LOAD;
      ST_LOAD:  if (load_done) nxt = ST_RUN;
      ST_RUN:   if (sw_req) nxt = ST_SWRST;
      ST_SWRST: if (cnt == CNT_LAST) nxt = strap ? ST_LOAD : ST_RUN;
      default:  nxt = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= ST_HOLD;
      cnt     <= '0;
      hold_o  <= 1'b1;
      grant_o <= 1'b0;
    end else begin
      state   <= nxt;
      cnt     <= (state == ST_SWRST && nxt == ST_SWRST) ? cnt + 1'b1 : '0;
      hold_o  <= (nxt != ST_RUN);
      grant_o <= (nxt == ST_LOAD);
    end
  end

  // R3: the grant persists while no load completion is seen
  a_r3_grant_waits: assert property (@(posedge clk) disable iff (rst)
    grant_o && !load_done |=> grant_o);
  // R4: load completion withdraws the grant on the next edge
  a_r4_grant_drops: assert property (@(posedge clk) disable iff (rst)
    grant_o && load_done |=> !grant_o);
  // R6: a request from a running core raises the hold on the next edge
  a_r6_sw_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) && sw_req |=> hold_o);
  // R7: hold counter never passes its limit
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SWRST) |-> (cnt <= CNT_LAST));
endmodule

// File: rtl/brc_gate_force.sv
module brc_gate_force #(
  parameter int N_GATES = 4
) (
  input  logic               force_on,
  input  logic [N_GATES-1:0] en_in,
  output logic [N_GATES-1:0] en_out
);
  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    assign en_out[g] = en_in[g] | force_on;
  end
endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int SW_HOLD     = 4,
  parameter int N_GATES     = 4
) (
  input  logic               clk,
  input  logic               por_rst,
  input  logic               load_done,
  input  logic               sw_reset_req,
  input  logic               boot_from_ram,
  input  logic               test_rst_bypass,
  input  logic               test_cg_bypass,
  input  logic [N_GATES-1:0] gate_en_in,
  output logic               dbg_rst,
  output logic               sys_rst,
  output logic               ram_grant,
  output logic [N_GATES-1:0] gate_en_out
);
  logic dbg_int, sys_int, fsm_rst, hold, sys_arst;

  brc_rst_sync #(.STAGES(SYNC_STAGES)) u_dbg_sync (
    .clk(clk), .arst(por_rst), .rst_out(dbg_int)
  );

  assign fsm_rst = dbg_int & ~test_rst_bypass;

  brc_seq_fsm #(.SW_HOLD(SW_HOLD)) u_fsm (
    .clk(clk), .rst(fsm_rst), .load_done(load_done), .sw_req(sw_reset_req),
    .strap(boot_from_ram), .hold_o(hold), .grant_o(ram_grant)
  );

  assign sys_arst = por_rst | hold;

  brc_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk(clk), .arst(sys_arst), .rst_out(sys_int)
  );

  assign dbg_rst = dbg_int & ~test_rst_bypass;
  assign sys_rst = sys_int & ~test_rst_bypass;

  brc_gate_force #(.N_GATES(N_GATES)) u_gates (
    .force_on(test_cg_bypass), .en_in(gate_en_in), .en_out(gate_en_out)
  );

  // R5: core held whenever the loader owns RAM
  a_r5_grant_holds_core: assert property (@(posedge clk) disable iff (por_rst)
    ram_grant |-> sys_int);
  // R6: debug reset is untouched by core-side activity
  a_r6_dbg_untouched: assert property (@(posedge clk) disable iff (por_rst)
    !dbg_int |=> !dbg_int);
endmodule

// File: tb/boot_reset_ctrl_test.sv
`timescale 1ns/1ps
module boot_reset_ctrl_test;
  localparam int SW_HOLD = 4;
  localparam int NG = 4;

  logic clk = 1'b0;
  logic por_rst = 1'b1, load_done = 1'b0, sw_reset_req = 1'b0, boot_from_ram = 1'b0;
  logic test_rst_bypass = 1'b0, test_cg_bypass = 1'b0;
  logic [NG-1:0] gate_en_in = '0;
  logic dbg_rst, sys_rst, ram_grant;
  logic [NG-1:0] gate_en_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  boot_reset_ctrl #(.SYNC_STAGES(2), .SW_HOLD(SW_HOLD), .N_GATES(NG)) uut (
    .clk(clk), .por_rst(por_rst), .load_done(load_done), .sw_reset_req(sw_reset_req),
    .boot_from_ram(boot_from_ram), .test_rst_bypass(test_rst_bypass),
    .test_cg_bypass(test_cg_bypass), .gate_en_in(gate_en_in),
    .dbg_rst(dbg_rst), .sys_rst(sys_rst), .ram_grant(ram_grant), .gate_en_out(gate_en_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_power_on;
    step(3);
    check("R1 dbg_rst under por", dbg_rst, 1);
    check("R1 sys_rst under por", sys_rst, 1);
    check("R1 grant under por", ram_grant, 0);
    por_rst = 1'b0;
    step(1);
    check("R2 dbg_rst after edge 1", dbg_rst, 1);
    step(1);
    check("R2 dbg_rst after edge 2", dbg_rst, 0);
    check("R3 grant not yet", ram_grant, 0);
    step(1);
    check("R3 grant raised", ram_grant, 1);
    check("R3 core held", sys_rst, 1);
    step(5);
    check("R3 grant held", ram_grant, 1);
    check("R5 core held in load", sys_rst, 1);
  endtask

  task automatic t_load;
    sw_reset_req = 1'b1;
    step(1);
    sw_reset_req = 1'b0;
    step(1);
    check("R9 sw req ignored in load grant", ram_grant, 1);
    check("R9 sw req ignored in load sys", sys_rst, 1);
    load_done = 1'b1;
    step(1);
    load_done = 1'b0;
    check("R4 grant dropped", ram_grant, 0);
    check("R4 core still held k", sys_rst, 1);
    step(1);
    check("R4 core still held k+1", sys_rst, 1);
    step(1);
    check("R4 core released k+2", sys_rst, 0);
  endtask

  task automatic t_run_ignore;
    load_done = 1'b1;
    step(2);
    load_done = 1'b0;
    step(3);
    check("R9 load_done ignored in run sys", sys_rst, 0);
    check("R9 load_done ignored in run grant", ram_grant, 0);
  endtask

  task automatic t_sw_reset_run;
    boot_from_ram = 1'b0;
    sw_reset_req = 1'b1;
    step(1);
    sw_reset_req = 1'b0;
    check("R6 sys asserted", sys_rst, 1);
    check("R6 dbg untouched", dbg_rst, 0);
    step(SW_HOLD + 1);
    check("R7 sys held edge SW_HOLD+1", sys_rst, 1);
    check("R7 no grant", ram_grant, 0);
    check("R6 dbg still released", dbg_rst, 0);
    step(1);
    check("R7 sys released edge SW_HOLD+2", sys_rst, 0);
  endtask

  task automatic t_sw_reset_strap;
    boot_from_ram = 1'b1;
    sw_reset_req = 1'b1;
    step(1);
    sw_reset_req = 1'b0;
    check("R8 sys asserted", sys_rst, 1);
    step(SW_HOLD - 1);
    check("R8 grant not yet", ram_grant, 0);
    step(1);
    check("R8 grant reopened", ram_grant, 1);
    step(6);
    check("R8 core held awaiting load", sys_rst, 1);
    load_done = 1'b1;
    step(1);
    load_done = 1'b0;
    step(2);
    check("R8 core released after reload", sys_rst, 0);
    boot_from_ram = 1'b0;
  endtask

  task automatic t_gates;
    gate_en_in = 4'b1010;
    test_cg_bypass = 1'b0;
    step(1);
    check("R11 pass-through a", gate_en_out, 4'b1010);
    gate_en_in = 4'b0101;
    step(1);
    check("R11 pass-through b", gate_en_out, 4'b0101);
    test_cg_bypass = 1'b1;
    step(1);
    check("R11 forced on", gate_en_out, 4'b1111);
    test_cg_bypass = 1'b0;
  endtask

  task automatic t_bypass;
    por_rst = 1'b1;
    step(2);
    check("R1 dbg re-asserted", dbg_rst, 1);
    test_rst_bypass = 1'b1;
    step(1);
    check("R10 dbg overridden", dbg_rst, 0);
    check("R10 sys overridden", sys_rst, 0);
    test_rst_bypass = 1'b0;
    step(1);
    check("R10 dbg back", dbg_rst, 1);
    check("R10 sys back", sys_rst, 1);
  endtask

  initial begin
    t_power_on();
    t_load();
    t_run_ignore();
    t_sw_reset_run();
    t_sw_reset_strap();
    t_gates();
    t_bypass();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule